// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block collects single-cycle event pulses from up to sixteen internal sources into a sticky status vector and presents a single level interrupt line to a host processor. The host reaches it through a small synchronous register bus: a mask register that can be written whole or changed bit by bit through separate set and clear aliases, two read windows onto the status vector (one that leaves it intact, one that empties it), and a write-one acknowledge register that retires chosen status bits.

A mask bit at 1 keeps its source from raising the interrupt, and after reset only source 0 is masked. The source map is fixed. Bit 0 is the first receive buffer, bit 1 is transmit data, bit 2 is transmit transfer, bit 3 is the second receive buffer, bit 4 is receive transfer, bits 5 and 6 are the two event mailboxes, bit 7 is wake, bits 8 and 9 are trace, bit 10 is command complete and bit 14 is init complete. Bits 11, 12, 13 and 15 are reserved and never latch. Reads are combinational: the read data is valid in the cycle the access is presented. Any change of state that the access causes takes effect at the next rising clock edge.

The register access decoder names each access as one of seven targets: REG_MASK, REG_MSET, REG_MCLR, REG_PEEK, REG_TAKE, REG_ACK and REG_NONE. The access then moves the mask and the status vector from one clock edge to the next. The block has no other sequencing state.

Top module: `hint_ctrl`

## Requirements
- R1: After reset the mask reads 0x0001, every status bit is 0 and irq_o is 0. An event on source 0 then latches into status but does not raise irq_o.
- R2: A write to address 0 (mask) loads the whole mask. A read of address 0 returns it.
- R3: A write to address 1 (mask set) sets the mask bits where the write data is 1 and leaves the others unchanged.
- R4: A write to address 2 (mask clear) clears the mask bits where the write data is 1 and leaves the others unchanged.
- R5: An event pulse on a used source (bits 0-10 and 14) sets its status bit at the next edge, and the bit holds until it is cleared. Events on bits 11, 12, 13 and 15 never set status.
- R6: A read of address 3 (peek) returns the status vector and does not change it.
- R7: A read of address 4 (take) returns the status vector, and every status bit is cleared at the next edge.
- R8: A write to address 5 (acknowledge) clears the status bits where the write data is 1. Bits where the write data is 0 are unaffected.
- R9: An event on a bit in the same cycle as a take read or an acknowledge of that bit wins, and the bit stays set.
- R10: irq_o is a register holding the OR of (status AND NOT mask). It follows a change of status or mask one clock edge later.
- R11: Reads of addresses 1, 2, 5, 6 and 7 return 0. Writes to addresses 3, 4, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_en_i | input | 1 | Bus access valid this cycle |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid in the access cycle; 0 when no read is presented |
| evt_i | input | 16 | Event pulses, one bit per source |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
A wrong mask or status bit first shows at the ports as a wrong read value on the mask or peek window in the cycle of the read. Without a read, it shows as irq_o taking the wrong level one edge after the bad state forms. Lost clears and lost events show on the next peek. A wrong clear-on-read shows on the peek that follows a take. The bench therefore reads back after every state-changing access and samples irq_o on each cycle, so a divergence is caught within two cycles of its cause.

// File: rtl/hint_pkg.sv
package hint_pkg;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_MASK = 3'd0;
    localparam logic [ADDR_W-1:0] A_MSET = 3'd1;
    localparam logic [ADDR_W-1:0] A_MCLR = 3'd2;
    localparam logic [ADDR_W-1:0] A_PEEK = 3'd3;
    localparam logic [ADDR_W-1:0] A_TAKE = 3'd4;
    localparam logic [ADDR_W-1:0] A_ACK  = 3'd5;

    typedef enum logic [2:0] {
        REG_NONE = 3'd0,
        REG_MASK = 3'd1,
        REG_MSET = 3'd2,
        REG_MCLR = 3'd3,
        REG_PEEK = 3'd4,
        REG_TAKE = 3'd5,
        REG_ACK  = 3'd6
    } reg_e;

endpackage

// File: rtl/hint_decode.sv
module hint_decode
    import hint_pkg::*;
(
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output reg_e              rd_sel_o,
    output reg_e              wr_sel_o
);

    reg_e target;

    always_comb begin
        unique case (addr_i)
            A_MASK:  target = REG_MASK;
            A_MSET:  target = REG_MSET;
            A_MCLR:  target = REG_MCLR;
            A_PEEK:  target = REG_PEEK;
            A_TAKE:  target = REG_TAKE;
            A_ACK:   target = REG_ACK;
            default: target = REG_NONE;
        endcase
    end

    always_comb begin
        rd_sel_o = REG_NONE;
        wr_sel_o = REG_NONE;
        if (en_i && !we_i) begin
            rd_sel_o = target;
        end
        if (en_i && we_i) begin
            wr_sel_o = target;
        end
    end

endmodule

// File: rtl/hint_mask_reg.sv
module hint_mask_reg
    import hint_pkg::*;
#(
    parameter int unsigned      SRC_W    = 16,
    parameter logic [SRC_W-1:0] MASK_RST = 16'h0001
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  reg_e             wr_sel_i,
    input  logic [SRC_W-1:0] wdata_i,
    output logic [SRC_W-1:0] mask_o
);

    logic [SRC_W-1:0] mask_d;

    always_comb begin
        mask_d = mask_o;
        unique case (wr_sel_i)
            REG_MASK: mask_d = wdata_i;
            REG_MSET: mask_d = mask_o | wdata_i;
            REG_MCLR: mask_d = mask_o & ~wdata_i;
            default:  mask_d = mask_o;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mask_o <= MASK_RST;
        end else begin
            mask_o <= mask_d;
        end
    end

endmodule

// File: rtl/hint_status_reg.sv
module hint_status_reg #(
    parameter int unsigned      SRC_W    = 16,
    parameter logic [SRC_W-1:0] SRC_USED = 16'h47FF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SRC_W-1:0] evt_i,
    input  logic [SRC_W-1:0] clr_i,
    output logic [SRC_W-1:0] stat_o
);

    for (genvar b = 0; b < SRC_W; b++) begin : g_bit
        if (SRC_USED[b]) begin : g_used
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    stat_o[b] <= 1'b0;
                end else if (evt_i[b]) begin
                    stat_o[b] <= 1'b1;
                end else if (clr_i[b]) begin
                    stat_o[b] <= 1'b0;
                end
            end
        end else begin : g_rsvd
            assign stat_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/hint_ctrl.sv
module hint_ctrl
    import hint_pkg::*;
#(
    parameter int unsigned      SRC_W    = 16,
    parameter logic [SRC_W-1:0] MASK_RST = 16'h0001,
    parameter logic [SRC_W-1:0] SRC_USED = 16'h47FF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [SRC_W-1:0]  bus_wdata_i,
    output logic [SRC_W-1:0]  bus_rdata_o,
    input  logic [SRC_W-1:0]  evt_i,
    output logic              irq_o
);

    localparam logic [SRC_W-1:0] ALL_ONES = {SRC_W{1'b1}};

    reg_e             rd_sel;
    reg_e             wr_sel;
    logic [SRC_W-1:0] mask_q;
    logic [SRC_W-1:0] stat_q;
    logic [SRC_W-1:0] clr_vec;
    logic             irq_d;

    hint_decode u_dec (
        .en_i     (bus_en_i),
        .we_i     (bus_we_i),
        .addr_i   (bus_addr_i),
        .rd_sel_o (rd_sel),
        .wr_sel_o (wr_sel)
    );

    hint_mask_reg #(
        .SRC_W    (SRC_W),
        .MASK_RST (MASK_RST)
    ) u_mask (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_sel_i (wr_sel),
        .wdata_i  (bus_wdata_i),
        .mask_o   (mask_q)
    );

    always_comb begin
        clr_vec = '0;
        if (rd_sel == REG_TAKE) begin
            clr_vec = ALL_ONES;
        end else if (wr_sel == REG_ACK) begin
            clr_vec = bus_wdata_i;
        end
    end

    hint_status_reg #(
        .SRC_W    (SRC_W),
        .SRC_USED (SRC_USED)
    ) u_stat (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .evt_i  (evt_i),
        .clr_i  (clr_vec),
        .stat_o (stat_q)
    );

    always_comb begin
        unique case (rd_sel)
            REG_MASK: bus_rdata_o = mask_q;
            REG_PEEK: bus_rdata_o = stat_q;
            REG_TAKE: bus_rdata_o = stat_q;
            default:  bus_rdata_o = '0;
        endcase
    end

    assign irq_d = |(stat_q & ~mask_q);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= irq_d;
        end
    end

endmodule

// File: rtl/hint_ctrl_chk.sv
module hint_ctrl_chk
    import hint_pkg::*;
#(
    parameter int unsigned      SRC_W    = 16,
    parameter logic [SRC_W-1:0] SRC_USED = 16'h47FF
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_en_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [SRC_W-1:0]  bus_wdata_i,
    input logic [SRC_W-1:0]  evt_i,
    input logic              irq_o,
    input logic [SRC_W-1:0]  stat_q,
    input logic [SRC_W-1:0]  mask_q
);

    logic rd_peek, rd_take, wr_set, wr_clr, wr_ack;

    assign rd_peek = bus_en_i && !bus_we_i && bus_addr_i == A_PEEK;
    assign rd_take = bus_en_i && !bus_we_i && bus_addr_i == A_TAKE;
    assign wr_set  = bus_en_i && bus_we_i && bus_addr_i == A_MSET;
    assign wr_clr  = bus_en_i && bus_we_i && bus_addr_i == A_MCLR;
    assign wr_ack  = bus_en_i && bus_we_i && bus_addr_i == A_ACK;

    assert_reserved_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_q & ~SRC_USED) == '0);

    assert_peek_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_peek && evt_i == '0) |=> stat_q == $past(stat_q));

    assert_take_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_take |=> stat_q == ($past(evt_i) & SRC_USED));

    assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_ack |=> (stat_q & $past(bus_wdata_i) & ~$past(evt_i)) == '0);

    assert_event_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((evt_i & SRC_USED) != '0) |=>
            (stat_q & $past(evt_i & SRC_USED)) == $past(evt_i & SRC_USED));

    assert_set_alias_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_set |=> ((mask_q & $past(bus_wdata_i)) == $past(bus_wdata_i)) &&
                   ((mask_q & ~$past(bus_wdata_i)) == ($past(mask_q) & ~$past(bus_wdata_i))));

    assert_clr_alias_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_clr |=> ((mask_q & $past(bus_wdata_i)) == '0) &&
                   ((mask_q & ~$past(bus_wdata_i)) == ($past(mask_q) & ~$past(bus_wdata_i))));

    assert_irq_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past((stat_q & ~mask_q) != '0));

endmodule

bind hint_ctrl hint_ctrl_chk #(
    .SRC_W    (SRC_W),
    .SRC_USED (SRC_USED)
) chk_i (.*);

// File: tb/hint_ctrl_tb.sv
module hint_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] evt = '0;
    logic [15:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hint_ctrl dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_en_i    (en),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .evt_i       (evt),
        .irq_o       (irq)
    );

    // row: en, we, addr, wdata, evt, expected rdata, expected irq (sampled before the edge)
    localparam int NV = 24;
    localparam logic [53:0] VEC [NV] = '{
        {1'b1, 1'b0, 3'd0, 16'h0000, 16'h0000, 16'h0001, 1'b0}, // R1 mask reset
        {1'b1, 1'b1, 3'd0, 16'h00F0, 16'h0000, 16'h0000, 1'b0}, // R2 write mask
        {1'b1, 1'b0, 3'd0, 16'h0000, 16'h0012, 16'h00F0, 1'b0}, // R2 read, R5 events
        {1'b1, 1'b0, 3'd3, 16'h0000, 16'h0000, 16'h0012, 1'b0}, // R5 latched, R10 not yet
        {1'b1, 1'b0, 3'd3, 16'h0000, 16'h0000, 16'h0012, 1'b1}, // R6 kept, R10 raised
        {1'b1, 1'b1, 3'd1, 16'h0002, 16'h0000, 16'h0000, 1'b1}, // R3 set alias
        {1'b1, 1'b0, 3'd0, 16'h0000, 16'h0000, 16'h00F2, 1'b1}, // R3 readback
        {1'b1, 1'b0, 3'd1, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R11 alias reads 0, R10
        {1'b1, 1'b1, 3'd2, 16'h00F0, 16'h0000, 16'h0000, 1'b0}, // R4 clear alias
        {1'b1, 1'b0, 3'd0, 16'h0000, 16'h0000, 16'h0002, 1'b0}, // R4 readback
        {1'b1, 1'b1, 3'd5, 16'h0010, 16'h0000, 16'h0000, 1'b1}, // R8 ack bit 4
        {1'b1, 1'b0, 3'd3, 16'h0000, 16'h0000, 16'h0002, 1'b1}, // R8 result
        {1'b1, 1'b1, 3'd3, 16'hFFFF, 16'h1000, 16'h0000, 1'b0}, // R11 write peek, R5 rsvd
        {1'b1, 1'b0, 3'd3, 16'h0000, 16'h0000, 16'h0002, 1'b0}, // R5 R11 unchanged
        {1'b1, 1'b0, 3'd4, 16'h0000, 16'h0400, 16'h0002, 1'b0}, // R7 take with new event
        {1'b1, 1'b0, 3'd3, 16'h0000, 16'h0000, 16'h0400, 1'b0}, // R7 cleared, new kept
        {1'b1, 1'b1, 3'd5, 16'h0400, 16'h0400, 16'h0000, 1'b1}, // R9 ack vs event
        {1'b1, 1'b0, 3'd3, 16'h0000, 16'h0000, 16'h0400, 1'b1}, // R9 event won
        {1'b1, 1'b0, 3'd4, 16'h0000, 16'h0400, 16'h0400, 1'b1}, // R9 take vs event
        {1'b1, 1'b0, 3'd3, 16'h0000, 16'h0000, 16'h0400, 1'b1}, // R9 event won
        {1'b1, 1'b0, 3'd4, 16'h0000, 16'h0000, 16'h0400, 1'b1}, // R7 take
        {1'b1, 1'b0, 3'd3, 16'h0000, 16'h0000, 16'h0000, 1'b1}, // R7 empty, R10 lag
        {1'b1, 1'b0, 3'd7, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R11 unmapped read
        {1'b1, 1'b0, 3'd5, 16'h0000, 16'h0000, 16'h0000, 1'b0}  // R11 ack reads 0
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic e, input logic w, input logic [2:0] a,
                         input logic [15:0] d, input logic [15:0] ev);
        en = e; we = w; addr = a; wdata = d; evt = ev;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        drive(1'b0, 1'b0, 3'd0, 16'h0, 16'h0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 irq after reset", {15'h0, irq}, 16'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][53], VEC[i][52], VEC[i][51:49], VEC[i][48:33], VEC[i][32:17]);
            #1;
            check($sformatf("row %0d rdata", i), rdata, VEC[i][16:1]);
            check($sformatf("row %0d irq R10", i), {15'h0, irq}, {15'h0, VEC[i][0]});
            step();
        end

        // R1: reset restores mask, and source 0 is masked
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 3'd0, 16'h0, 16'h0001);
        #1 check("R1 mask reset", rdata, 16'h0001);
        step();
        drive(1'b1, 1'b0, 3'd3, 16'h0, 16'h0);
        #1 check("R1 src0 latched", rdata, 16'h0001);
        step();
        #1 check("R1 src0 masked irq", {15'h0, irq}, 16'h0);
        drive(1'b1, 1'b1, 3'd2, 16'h0001, 16'h0);
        step();
        #1 check("R10 irq lags mask", {15'h0, irq}, 16'h0);
        step();
        #1 check("R10 irq after unmask", {15'h0, irq}, 16'h1);

        // R10 latency from a fresh event
        drive(1'b1, 1'b1, 3'd5, 16'hFFFF, 16'h0);
        step();
        step();
        #1 check("R8 full ack irq low", {15'h0, irq}, 16'h0);
        drive(1'b0, 1'b0, 3'd0, 16'h0, 16'h0008);
        step();
        #1 check("R10 one edge after event", {15'h0, irq}, 16'h0);
        step();
        #1 check("R10 two edges after event", {15'h0, irq}, 16'h1);

        // R2 full mask write silences irq; R11 write to take window ignored
        drive(1'b1, 1'b1, 3'd0, 16'hFFFF, 16'h0);
        step();
        drive(1'b1, 1'b1, 3'd4, 16'h0000, 16'h0);
        step();
        #1 check("R2 masked all irq", {15'h0, irq}, 16'h0);
        drive(1'b1, 1'b0, 3'd3, 16'h0, 16'h0);
        #1 check("R11 take write no clear", rdata, 16'h0008);
        step();

        done = 1'b1;
        finish_run();
    end

endmodule